// File: doc/BRIEF.md
# Bitwise Priority Arbitration Front End

This block is the contention stage of a serial node that shares a wired bus with other nodes. On the bus a driven low (dominant) level overrides a high (recessive) level, so the bus behaves as the AND of every node's output. When told to begin a frame, the node places its identifier on the bus one bit per bit-time, most significant bit first, and at every bit-time strobe it compares the level it placed with the level it reads back.

A node that placed recessive but reads dominant has been outbid by a node with a lower identifier. It raises its lost flag, lets its output go recessive and stays silent until the next frame start. A node that gets through every identifier bit with no such mismatch raises its won flag and owns the bus. Because the winner's bits were never disturbed, contention costs no frame and needs no retry: the lowest identifier always goes through.

Top module: `bitarb_node`

## Requirements
- R1: After reset the output is recessive (1) and busy, lost and won are all 0.
- R2: The cycle after a start pulse, busy is 1, lost and won are 0, and the output shows bit ID_W-1 of the identifier given with the start.
- R3: Each bit strobe that finds no mismatch moves the output to the next less significant identifier bit, visible the cycle after the strobe.
- R4: A bit strobe at which the output is recessive (1) and the bus reads dominant (0) sets lost the next cycle and clears busy.
- R5: A strobe at which the node drives dominant and reads dominant, or drives recessive and reads recessive, does not set lost.
- R6: Once lost, the output stays recessive and lost stays set through any later strobes until the next start.
- R7: If the strobe sampling identifier bit 0 finds no mismatch, won is set the next cycle, busy clears and the output returns to recessive; lost and won are never both set.
- R8: A start pulse during a frame, or after a lost or won result, restarts arbitration with the new identifier and clears lost and won.
- R9: Bit strobes while idle (no start since reset) have no effect on any output.
- R10: When several nodes start together with distinct identifiers on a shared AND bus, exactly the node with the smallest identifier wins and every other node loses.
- R11: Between strobes during arbitration the output and busy hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse: latch the identifier and begin arbitration |
| bit_tick | input | 1 | One-cycle bit-time strobe; the bus is sampled on this cycle |
| ident | input | ID_W | Identifier, latched on start |
| bus_rx | input | 1 | Level read back from the shared bus (0 dominant) |
| tx_out | output | 1 | Level driven onto the bus (0 dominant, 1 recessive) |
| busy | output | 1 | Arbitration in progress |
| lost | output | 1 | Arbitration lost; node has released the bus |
| won | output | 1 | All identifier bits sent without losing |

## Verification
The bench builds three nodes at the default ID_W of 11 and joins their outputs, plus a forcing term, into one AND bus, so real contention arises between nodes rather than from scripted readback. This reaches losses at the first bit, a decision that hangs on the least significant bit, shared dominant bits that must not count as losses, an all-lose case from a forced dominant level, and restarts both mid-frame and after a result.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam logic LVL_DOM = 1'b0;
    localparam logic LVL_REC = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_LOST = 2'd2,
        ST_WON  = 2'd3
    } arb_state_e;

endpackage

// File: rtl/arb_shift.sv
module arb_shift #(
    parameter int ID_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            advance,
    input  logic [ID_W-1:0] ident,
    output logic            cur_bit,
    output logic            last_bit
);
    localparam int CNT_W = (ID_W > 1) ? $clog2(ID_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ID_W - 1);

    typedef struct packed {
        logic [ID_W-1:0]  sr;
        logic [CNT_W-1:0] cnt;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.sr  = ident;
            sh_d.cnt = '0;
        end else if (advance) begin
            sh_d.sr  = {sh_q.sr[ID_W-2:0], arb_pkg::LVL_REC};
            sh_d.cnt = sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.sr  <= '1;
            sh_q.cnt <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign cur_bit  = sh_q.sr[ID_W-1];
    assign last_bit = (sh_q.cnt == LAST_IDX);

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bit_tick,
    input  logic bus_rx,
    input  logic cur_bit,
    input  logic last_bit,
    output logic load,
    output logic advance,
    output logic tx_out,
    output logic busy,
    output logic lost,
    output logic won
);
    import arb_pkg::*;

    typedef struct packed {
        arb_state_e st;
    } fsm_t;

    fsm_t f_d, f_q;
    logic conflict;

    always_comb begin
        conflict = (f_q.st == ST_ARB) && bit_tick &&
                   (cur_bit == LVL_REC) && (bus_rx == LVL_DOM);
        f_d      = f_q;
        load     = start;
        advance  = 1'b0;
        if (start) begin
            f_d.st = ST_ARB;
        end else if (f_q.st == ST_ARB && bit_tick) begin
            if (conflict) begin
                f_d.st = ST_LOST;
            end else if (last_bit) begin
                f_d.st = ST_WON;
            end else begin
                advance = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign busy   = (f_q.st == ST_ARB);
    assign lost   = (f_q.st == ST_LOST);
    assign won    = (f_q.st == ST_WON);
    assign tx_out = busy ? cur_bit : LVL_REC;

endmodule

// File: rtl/bitarb_node.sv
module bitarb_node #(
    parameter int ID_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            bit_tick,
    input  logic [ID_W-1:0] ident,
    input  logic            bus_rx,
    output logic            tx_out,
    output logic            busy,
    output logic            lost,
    output logic            won
);
    logic load, advance, cur_bit, last_bit;

    arb_shift #(.ID_W(ID_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .advance  (advance),
        .ident    (ident),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    arb_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .bit_tick (bit_tick),
        .bus_rx   (bus_rx),
        .cur_bit  (cur_bit),
        .last_bit (last_bit),
        .load     (load),
        .advance  (advance),
        .tx_out   (tx_out),
        .busy     (busy),
        .lost     (lost),
        .won      (won)
    );

endmodule

// File: rtl/bitarb_node_chk.sv
module bitarb_node_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic bit_tick,
    input logic bus_rx,
    input logic tx_out,
    input logic busy,
    input logic lost,
    input logic won
);
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !lost && !won));

    p_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bit_tick && !start && tx_out && !bus_rx) |=> lost);

    p_no_false_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bit_tick && !start && (tx_out == bus_rx)) |=> !lost);

    p_lost_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && !start) |=> (lost && tx_out));

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lost && won) && !(busy && (lost || won)));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick && !start) |=> (busy && $stable(tx_out)));
endmodule

bind bitarb_node bitarb_node_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bit_tick (bit_tick),
    .bus_rx   (bus_rx),
    .tx_out   (tx_out),
    .busy     (busy),
    .lost     (lost),
    .won      (won)
);

// File: tb/test_bitarb_node.sv
module test_bitarb_node;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W = 11;
    localparam int N = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic jam = 1'b1;
    logic [N-1:0] start = '0;
    logic [ID_W-1:0] ident [N];
    logic [N-1:0] tx_v, busy_v, lost_v, won_v;
    logic bus;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // reference model: 0 idle, 1 arbitrating, 2 lost, 3 won
    int m_st [N];
    int m_idx [N];
    logic [ID_W-1:0] m_id [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus = jam & (&tx_v);

    for (genvar g = 0; g < N; g++) begin : g_node
        bitarb_node #(.ID_W(ID_W)) i_bitarb_node (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start[g]),
            .bit_tick (bit_tick),
            .ident    (ident[g]),
            .bus_rx   (bus),
            .tx_out   (tx_v[g]),
            .busy     (busy_v[g]),
            .lost     (lost_v[g]),
            .won      (won_v[g])
        );
    end

    function automatic logic m_tx(int i);
        return (m_st[i] == 1) ? m_id[i][m_idx[i]] : 1'b1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_st[i] = 0; m_idx[i] = ID_W-1; m_id[i] = '1;
            end
        end else begin
            logic mbus;
            logic mtx [N];
            mbus = jam;
            for (int i = 0; i < N; i++) begin
                mtx[i] = m_tx(i);
                mbus = mbus & mtx[i];
            end
            for (int i = 0; i < N; i++) begin
                if (start[i]) begin
                    m_st[i] = 1; m_idx[i] = ID_W-1; m_id[i] = ident[i];
                end else if (bit_tick && m_st[i] == 1) begin
                    if (mtx[i] == 1'b1 && mbus == 1'b0) m_st[i] = 2;
                    else if (m_idx[i] == 0) m_st[i] = 3;
                    else m_idx[i] = m_idx[i] - 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < N; i++) begin
                chk(tx_v[i] == m_tx(i), "R3 tx", int'(tx_v[i]), int'(m_tx(i)));
                chk(busy_v[i] == (m_st[i] == 1), "R2 busy", int'(busy_v[i]), int'(m_st[i] == 1));
                chk(lost_v[i] == (m_st[i] == 2), "R4 lost", int'(lost_v[i]), int'(m_st[i] == 2));
                chk(won_v[i] == (m_st[i] == 3), "R7 won", int'(won_v[i]), int'(m_st[i] == 3));
            end
        end
    end

    task automatic finish_up;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic go(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b, input logic [ID_W-1:0] c);
        @(negedge clk);
        ident[0] = a; ident[1] = b; ident[2] = c;
        start = '1;
        @(negedge clk);
        start = '0;
    endtask

    task automatic check_winner;
        int mi;
        mi = 0;
        for (int i = 1; i < N; i++) if (ident[i] < ident[mi]) mi = i;
        for (int i = 0; i < N; i++) begin
            if (i == mi) chk(won_v[i] && !lost_v[i], "R10 smallest wins", int'(won_v[i]), 1);
            else chk(lost_v[i] && !won_v[i], "R10 others lose", int'(lost_v[i]), 1);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) ident[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(tx_v == '1 && busy_v == '0 && lost_v == '0 && won_v == '0, "R1 reset",
            int'({tx_v, busy_v, lost_v, won_v}), int'({3'b111, 9'b0}));
        rst_n = 1'b1;
        @(negedge clk);
        // R9 strobes while idle
        tick_n(3);
        chk(tx_v == '1 && busy_v == '0 && lost_v == '0 && won_v == '0, "R9 idle strobes",
            int'({tx_v, busy_v, lost_v, won_v}), int'({3'b111, 9'b0}));

        // contest 1: shared dominant leading bits
        go(11'h123, 11'h0F0, 11'h3FF);
        chk(busy_v == '1 && tx_v == 3'b000, "R2 start msb", int'({busy_v, tx_v}), int'({3'b111, 3'b000}));
        repeat (3) @(negedge clk);
        chk(tx_v == 3'b000 && busy_v == '1, "R11 hold", int'({busy_v, tx_v}), int'({3'b111, 3'b000}));
        tick_n(1);
        chk(lost_v == '0 && busy_v == '1, "R5 dominant readback", int'(lost_v), 0);
        tick_n(ID_W-1);
        check_winner();
        chk(tx_v == '1, "R7 release", int'(tx_v), 7);

        // contest 2: decided at the last bit
        go(11'h555, 11'h554, 11'h556);
        tick_n(ID_W);
        check_winner();

        // contest 3: restart after first-bit losses
        go(11'h700, 11'h000, 11'h7FF);
        tick_n(4);
        chk(lost_v == 3'b101, "R4 first-bit loss", int'(lost_v), 5);
        go(11'h200, 11'h100, 11'h300);
        chk(busy_v == '1 && lost_v == '0 && won_v == '0, "R8 restart", int'({busy_v, lost_v}), int'({3'b111, 3'b000}));
        tick_n(ID_W);
        check_winner();

        // forced dominant level: every recessive sender loses
        go(11'h7FF, 11'h7FE, 11'h7FD);
        @(negedge clk); jam = 1'b0; bit_tick = 1'b1;
        @(negedge clk); jam = 1'b1; bit_tick = 1'b0;
        @(negedge clk);
        chk(lost_v == '1, "R4 forced dominant", int'(lost_v), 7);
        tick_n(ID_W);
        chk(lost_v == '1 && tx_v == '1 && won_v == '0, "R6 sticky loss", int'({lost_v, tx_v}), 63);

        // start after a result with an extreme identifier spread
        go(11'h000, 11'h7FF, 11'h400);
        tick_n(ID_W);
        check_winner();

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule